// File: doc/BRIEF.md
# Bit Test-and-Modify Memory Sequencer

This block carries out the two bit-mask read-modify-write operations of a 16-bit accumulator core. One of them sets the accumulator's bits in a memory operand and the other clears them. A single start pulse with an opcode launches the operation. The block forms the effective address from either the direct-page register and an 8-bit offset, or the data bank register and a 16-bit operand. It reads the operand over a byte-wide bus with one cycle of read latency and tests it against the accumulator. It then writes the modified value back and reports the zero flag and the instruction's cycle cost.

The M flag selects the operand width. With M set, one byte is handled and only the low byte of the accumulator is used. With M clear, a little-endian 16-bit word is handled. Instruction fetch and every flag except zero belong to the surrounding core.

Top module: `bit_test_rmw`

## Requirements
- R1: Only the opcodes 0x04 (set bits, direct page), 0x0C (set bits, absolute), 0x14 (clear bits, direct page) and 0x1C (clear bits, absolute) are accepted. A start with any other opcode causes no bus read or write and no done pulse, and leaves zero_o and cyc_o unchanged.
- R2: The direct-page address is the zero-extended 16-bit direct-page register plus the zero-extended low byte of the operand, and a carry propagates into bit 16. The absolute address is the bank register in bits 23:16 and the 16-bit operand in bits 15:0.
- R3: zero_o is 1 when the value read, ANDed with the accumulator at the active width, is zero, and 0 otherwise. The test uses memory before modification.
- R4: The set-bits forms write back memory OR accumulator. The clear-bits forms write back memory AND NOT accumulator.
- R5: With m8_i = 1, exactly one byte is read and one byte is written, at the effective address, and the byte at address+1 is untouched. With m8_i = 0, the low byte is at the address and the high byte at address+1, modulo 2^24. Two reads precede two writes, and each pair goes low byte first.
- R6: cyc_o reports the cost. Direct page costs 5 cycles for 8-bit and 6 for 16-bit, plus 1 when the low byte of the direct-page register is nonzero. Absolute costs 6 cycles for 8-bit and 7 for 16-bit.
- R7: done_o is a one-cycle pulse. It comes in the 4th cycle after the start edge for 8-bit operations and in the 6th for 16-bit ones. Read and write strobes are never high together, and a write never directly follows a read.
- R8: A start pulse while an operation is in progress is ignored.
- R9: During and right after reset, mem_rd_o, mem_wr_o, done_o and zero_o are 0 and cyc_o is 0.
- R10: zero_o and cyc_o change only in the cycle done_o rises and hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch strobe, sampled on the rising edge |
| opcode_i | input | 8 | Operation code |
| operand_i | input | 16 | Offset (low byte) or absolute address |
| acc_i | input | 16 | Accumulator mask |
| dpage_i | input | 16 | Direct-page base register |
| bank_i | input | 8 | Data bank register |
| m8_i | input | 1 | 1: byte operation, 0: word operation |
| mem_addr_o | output | 24 | Byte address |
| mem_rd_o | output | 1 | Read strobe; data returns the next cycle |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, one cycle after mem_rd_o |
| zero_o | output | 1 | Zero flag result |
| cyc_o | output | 4 | Cycle cost of the last operation |
| done_o | output | 1 | Completion pulse |

## Verification
The bench builds the block with its default widths: a 24-bit address, byte lanes of 8 bits and a 4-bit cost counter. At these values a direct-page sum can carry out of bit 15 into bank 1. An absolute word at the top of the address space can also wrap its high byte to address zero, and both corners are driven. The vectors cover every opcode at both widths, direct-page bases with zero and nonzero low bytes, and accumulators whose high byte must not affect a byte test.

// File: rtl/bit_rmw_pkg.sv
package bit_rmw_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_LO,
    S_RD_HI,
    S_CAP,
    S_WR_LO,
    S_WR_HI,
    S_DONE
  } rmw_state_e;

  localparam logic [7:0] OPC_SET_DP  = 8'h04;
  localparam logic [7:0] OPC_SET_ABS = 8'h0C;
  localparam logic [7:0] OPC_CLR_DP  = 8'h14;
  localparam logic [7:0] OPC_CLR_ABS = 8'h1C;

  typedef struct packed {
    logic valid;
    logic set;
    logic dp;
  } rmw_op_t;

  function automatic rmw_op_t decode_op(input logic [7:0] opc);
    rmw_op_t r;
    r = '0;
    unique case (opc)
      OPC_SET_DP:  r = '{valid: 1'b1, set: 1'b1, dp: 1'b1};
      OPC_SET_ABS: r = '{valid: 1'b1, set: 1'b1, dp: 1'b0};
      OPC_CLR_DP:  r = '{valid: 1'b1, set: 1'b0, dp: 1'b1};
      OPC_CLR_ABS: r = '{valid: 1'b1, set: 1'b0, dp: 1'b0};
      default:     r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rmw_seq.sv
module rmw_seq
  import bit_rmw_pkg::*;
#(
  parameter int CYC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [7:0]       opcode_i,
  input  logic             m8_i,
  input  logic             dp_lo_nz_i,
  output logic             accept_o,
  output logic             set_o,
  output logic             dp_o,
  output logic             m8_o,
  output logic             rd_o,
  output logic             wr_o,
  output logic             hi_o,
  output logic             fin_o,
  output logic             done_o,
  output logic [CYC_W-1:0] cyc_o
);

  localparam logic [CYC_W-1:0] BASE_DP  = CYC_W'(5);
  localparam logic [CYC_W-1:0] BASE_ABS = CYC_W'(6);

  rmw_state_e       state_q, state_d;
  rmw_op_t          dec, op_q;
  logic             m8_q;
  logic [CYC_W-1:0] cost_d, cost_q, cyc_q;

  assign dec      = decode_op(opcode_i);
  assign accept_o = start_i && (state_q == S_IDLE) && dec.valid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (accept_o) state_d = S_RD_LO;
      S_RD_LO: state_d = m8_q ? S_CAP : S_RD_HI;
      S_RD_HI: state_d = S_CAP;
      S_CAP:   state_d = S_WR_LO;
      S_WR_LO: state_d = m8_q ? S_DONE : S_WR_HI;
      S_WR_HI: state_d = S_DONE;
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // cost is fixed by the inputs seen at launch
  always_comb begin
    if (dec.dp)
      cost_d = BASE_DP + CYC_W'(!m8_i) + CYC_W'(dp_lo_nz_i);
    else
      cost_d = BASE_ABS + CYC_W'(!m8_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= '0;
      m8_q    <= 1'b0;
      cost_q  <= '0;
      cyc_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept_o) begin
        op_q   <= dec;
        m8_q   <= m8_i;
        cost_q <= cost_d;
      end
      if (fin_o) cyc_q <= cost_q;
    end
  end

  assign set_o  = op_q.set;
  assign dp_o   = dec.dp;
  assign m8_o   = m8_q;
  assign rd_o   = (state_q == S_RD_LO) || (state_q == S_RD_HI);
  assign wr_o   = (state_q == S_WR_LO) || (state_q == S_WR_HI);
  assign hi_o   = (state_q == S_RD_HI) || (state_q == S_WR_HI);
  assign fin_o  = (state_q == S_WR_HI) || ((state_q == S_WR_LO) && m8_q);
  assign done_o = (state_q == S_DONE);
  assign cyc_o  = cyc_q;

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_cyc_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cyc_o >= CYC_W'(5)) && (cyc_o <= CYC_W'(8)));

  p_busy_ignore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE) && start_i |=> !rd_o || hi_o || $past(rd_o));

endmodule

// File: rtl/rmw_addr.sv
module rmw_addr #(
  parameter int ADDR_W = 24,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              dp_i,
  input  logic [2*BYTE_W-1:0] dpage_i,
  input  logic [2*BYTE_W-1:0] operand_i,
  input  logic [ADDR_W-2*BYTE_W-1:0] bank_i,
  input  logic              hi_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int WORD_W = 2 * BYTE_W;
  localparam int BANK_W = ADDR_W - WORD_W;

  logic [ADDR_W-1:0] base_d, base_q;

  always_comb begin
    if (dp_i)
      base_d = {{BANK_W{1'b0}}, dpage_i} + ADDR_W'(operand_i[BYTE_W-1:0]);
    else
      base_d = {bank_i, operand_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       base_q <= '0;
    else if (accept_i) base_q <= base_d;
  end

  // high byte sits one above, wrapping modulo 2^ADDR_W
  assign addr_o = base_q + ADDR_W'(hi_i);

endmodule

// File: rtl/rmw_datapath.sv
module rmw_datapath #(
  parameter int BYTE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                accept_i,
  input  logic                set_i,
  input  logic                m8_i,
  input  logic [2*BYTE_W-1:0] acc_i,
  input  logic                rd_i,
  input  logic                hi_i,
  input  logic [BYTE_W-1:0]   rdata_i,
  input  logic                fin_i,
  output logic [BYTE_W-1:0]   wdata_o,
  output logic                zero_o
);

  localparam int LANES  = 2;
  localparam int WORD_W = LANES * BYTE_W;

  logic [WORD_W-1:0] acc_q;
  logic              rd_q, hi_q, zero_q;
  logic [BYTE_W-1:0] data_q [LANES];
  logic [BYTE_W-1:0] new_b  [LANES];
  logic [LANES-1:0]  hit, en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      rd_q  <= 1'b0;
      hi_q  <= 1'b0;
    end else begin
      if (accept_i) acc_q <= acc_i;
      rd_q <= rd_i;
      hi_q <= hi_i;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] a_b;
    assign a_b = acc_q[g*BYTE_W +: BYTE_W];

    // read data lands one cycle after its strobe
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            data_q[g] <= '0;
      else if (rd_q && (hi_q == (g != 0)))    data_q[g] <= rdata_i;
    end

    assign new_b[g] = set_i ? (data_q[g] | a_b) : (data_q[g] & ~a_b);
    assign hit[g]   = |(data_q[g] & a_b);
    assign en[g]    = (g == 0) || !m8_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    zero_q <= 1'b0;
    else if (fin_i) zero_q <= ~|(hit & en);
  end

  assign wdata_o = hi_i ? new_b[1] : new_b[0];
  assign zero_o  = zero_q;

  p_zero_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fin_i |=> $stable(zero_o));

endmodule

// File: rtl/bit_test_rmw.sv
module bit_test_rmw #(
  parameter int ADDR_W = 24,
  parameter int BYTE_W = 8,
  parameter int CYC_W  = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [7:0]                 opcode_i,
  input  logic [2*BYTE_W-1:0]        operand_i,
  input  logic [2*BYTE_W-1:0]        acc_i,
  input  logic [2*BYTE_W-1:0]        dpage_i,
  input  logic [ADDR_W-2*BYTE_W-1:0] bank_i,
  input  logic                       m8_i,
  output logic [ADDR_W-1:0]          mem_addr_o,
  output logic                       mem_rd_o,
  output logic                       mem_wr_o,
  output logic [BYTE_W-1:0]          mem_wdata_o,
  input  logic [BYTE_W-1:0]          mem_rdata_i,
  output logic                       zero_o,
  output logic [CYC_W-1:0]           cyc_o,
  output logic                       done_o
);

  logic accept, set_op, dp_sel, m8_q, rd, wr, hi, fin;

  rmw_seq #(.CYC_W(CYC_W)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .opcode_i   (opcode_i),
    .m8_i       (m8_i),
    .dp_lo_nz_i (|dpage_i[BYTE_W-1:0]),
    .accept_o   (accept),
    .set_o      (set_op),
    .dp_o       (dp_sel),
    .m8_o       (m8_q),
    .rd_o       (rd),
    .wr_o       (wr),
    .hi_o       (hi),
    .fin_o      (fin),
    .done_o     (done_o),
    .cyc_o      (cyc_o)
  );

  rmw_addr #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) i_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .dp_i      (dp_sel),
    .dpage_i   (dpage_i),
    .operand_i (operand_i),
    .bank_i    (bank_i),
    .hi_i      (hi),
    .addr_o    (mem_addr_o)
  );

  rmw_datapath #(.BYTE_W(BYTE_W)) i_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .set_i    (set_op),
    .m8_i     (m8_q),
    .acc_i    (acc_i),
    .rd_i     (rd),
    .hi_i     (hi),
    .rdata_i  (mem_rdata_i),
    .fin_i    (fin),
    .wdata_o  (mem_wdata_o),
    .zero_o   (zero_o)
  );

  assign mem_rd_o = rd;
  assign mem_wr_o = wr;

  p_rd_wr_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  p_wr_after_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_wr_o) |-> !$past(mem_rd_o));

  p_wr_burst_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o && $past(mem_wr_o) |-> mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1));

  p_cyc_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(cyc_o));

endmodule

// File: tb/test_bit_test_rmw.sv
module test_bit_test_rmw;

  typedef struct packed {
    logic [7:0]  op;
    logic [15:0] opnd;
    logic [15:0] acc;
    logic [15:0] dpg;
    logic [7:0]  bank;
    logic        m8;
    logic [7:0]  lo;
    logic [7:0]  hi;
    logic [3:0]  cyc;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'h04, 16'h0010, 16'h0081, 16'h0000, 8'h00, 1'b1, 8'h01, 8'h55, 4'd5},
    '{8'h14, 16'h0020, 16'h000F, 16'h0100, 8'h00, 1'b1, 8'hF0, 8'h66, 4'd5},
    '{8'h04, 16'h0005, 16'h1234, 16'h0230, 8'h00, 1'b0, 8'h00, 8'hC0, 4'd7},
    '{8'h14, 16'h00FF, 16'h8001, 16'hFF01, 8'h00, 1'b0, 8'h03, 8'h81, 4'd7},
    '{8'h0C, 16'h3344, 16'hAA55, 16'h0000, 8'h12, 1'b1, 8'hAA, 8'h77, 4'd6},
    '{8'h1C, 16'hFFFF, 16'h00F0, 16'h0000, 8'hFF, 1'b0, 8'hF3, 8'h7E, 4'd7},
    '{8'h0C, 16'h0200, 16'hFFFF, 16'h0000, 8'h00, 1'b0, 8'h00, 8'h00, 4'd7},
    '{8'h14, 16'h0080, 16'hFF00, 16'h0001, 8'h00, 1'b1, 8'hFF, 8'h5A, 4'd6}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [15:0] operand = '0, acc = '0, dpage = '0;
  logic [7:0]  bank = '0;
  logic        m8 = 1'b0;
  logic [23:0] addr;
  logic        rd, wr, zero, done;
  logic [7:0]  wdata, rdata;
  logic [3:0]  cyc;

  logic [7:0]  mem [0:1023];
  logic [23:0] wa [0:3];
  logic [7:0]  wd [0:3];
  int          wcnt, rcnt;
  logic        log_clr = 1'b0;
  int          n_chk = 0, n_bad = 0;
  bit          ended = 1'b0;

  always #10ns clk = ~clk;

  bit_test_rmw i_bit_test_rmw (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opcode),
    .operand_i(operand), .acc_i(acc), .dpage_i(dpage), .bank_i(bank),
    .m8_i(m8), .mem_addr_o(addr), .mem_rd_o(rd), .mem_wr_o(wr),
    .mem_wdata_o(wdata), .mem_rdata_i(rdata), .zero_o(zero),
    .cyc_o(cyc), .done_o(done)
  );

  always @(posedge clk) begin
    if (log_clr) begin
      wcnt <= 0;
      rcnt <= 0;
    end else begin
      if (wr) begin
        if (wcnt < 4) begin
          wa[wcnt] <= addr;
          wd[wcnt] <= wdata;
        end
        wcnt <= wcnt + 1;
        mem[addr[9:0]] <= wdata;
      end
      if (rd) begin
        rcnt  <= rcnt + 1;
        rdata <= mem[addr[9:0]];
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    log_clr = 1'b1;
    @(negedge clk);
    log_clr = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input bit poke);
    logic [23:0] ea, ea1;
    logic        is_dp, is_set, exp_z;
    logic [15:0] w, nw;
    logic [7:0]  nlo, nhi;
    int          lat;
    is_dp  = (v.op == 8'h04) || (v.op == 8'h14);
    is_set = (v.op == 8'h04) || (v.op == 8'h0C);
    ea  = is_dp ? (24'(v.dpg) + 24'(v.opnd[7:0])) : {v.bank, v.opnd};
    ea1 = ea + 24'd1;
    w   = {v.hi, v.lo};
    if (v.m8) begin
      exp_z = ((v.lo & v.acc[7:0]) == 8'h00);
      nlo   = is_set ? (v.lo | v.acc[7:0]) : (v.lo & ~v.acc[7:0]);
      nhi   = v.hi;
    end else begin
      exp_z = ((w & v.acc) == 16'h0000);
      nw    = is_set ? (w | v.acc) : (w & ~v.acc);
      nlo   = nw[7:0];
      nhi   = nw[15:8];
    end
    mem[ea[9:0]]  = v.lo;
    mem[ea1[9:0]] = v.hi;
    clear_log();
    opcode = v.op; operand = v.opnd; acc = v.acc; dpage = v.dpg;
    bank = v.bank; m8 = v.m8; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      if (poke) start = (lat == 2);
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    chk("R7", "done latency", 32'(lat), v.m8 ? 32'd4 : 32'd6);
    chk("R6", "cycle cost", 32'(cyc), 32'(v.cyc));
    chk("R3", "zero flag", 32'(zero), 32'(exp_z));
    chk("R5", "write count", 32'(wcnt), v.m8 ? 32'd1 : 32'd2);
    chk("R5", "read count", 32'(rcnt), v.m8 ? 32'd1 : 32'd2);
    chk("R2", "low address", 32'(wa[0]), 32'(ea));
    chk("R4", "low data", 32'(wd[0]), 32'(nlo));
    if (!v.m8) begin
      chk("R5", "high address", 32'(wa[1]), 32'(ea1));
      chk("R4", "high data", 32'(wd[1]), 32'(nhi));
    end else begin
      chk("R5", "byte above untouched", 32'(mem[ea1[9:0]]), 32'(v.hi));
    end
    @(negedge clk);
    chk("R7", "done single pulse", 32'(done), 32'd0);
  endtask

  initial begin
    int dn;
    logic       z_keep;
    logic [3:0] c_keep;
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    wcnt = 0; rcnt = 0; rdata = 8'h00;
    repeat (3) @(negedge clk);
    chk("R9", "rd in reset", 32'(rd), 32'd0);
    chk("R9", "wr in reset", 32'(wr), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "done after reset", 32'(done), 32'd0);
    chk("R9", "zero after reset", 32'(zero), 32'd0);
    chk("R9", "cyc after reset", 32'(cyc), 32'd0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);

    // R10: results hold after completion
    z_keep = zero; c_keep = cyc;
    repeat (5) @(negedge clk);
    chk("R10", "zero held", 32'(zero), 32'(z_keep));
    chk("R10", "cyc held", 32'(cyc), 32'(c_keep));

    // R1: unknown opcode is ignored
    clear_log();
    opcode = 8'h1D; m8 = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dn = 0;
    for (int k = 0; k < 8; k++) begin
      if (done) dn++;
      @(negedge clk);
    end
    chk("R1", "done on bad opcode", 32'(dn), 32'd0);
    chk("R1", "writes on bad opcode", 32'(wcnt), 32'd0);
    chk("R1", "reads on bad opcode", 32'(rcnt), 32'd0);
    chk("R1", "zero unchanged", 32'(zero), 32'(z_keep));
    chk("R1", "cyc unchanged", 32'(cyc), 32'(c_keep));

    // R8: restart during a word operation
    run_vec(VECS[3], 1'b1);
    dn = 0;
    for (int k = 0; k < 8; k++) begin
      if (done) dn++;
      @(negedge clk);
    end
    chk("R8", "no second completion", 32'(dn), 32'd0);
    chk("R8", "no extra writes", 32'(wcnt), 32'd2);

    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(20ns * 200000);
    if (!ended) begin
      ended = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule